// File: doc/BRIEF.md
# Bit-Field Insert/Extract and Byte-Pick Unit

This unit performs four kinds of bit manipulation for a 64-bit integer datapath. Insert writes the low bits of a source into a chosen bit range of the old destination value. Extract pulls a bit range out of a source and places it at bit 0. Byte pick joins two sources and takes a byte-aligned window that spans both. The mask step passes one source through or forces zero, depending on whether a second source is zero. Insert, extract and byte pick each come in a 32-bit word form and a 64-bit doubleword form. Every word form returns its 32-bit answer sign-extended to 64 bits.

Each operation arrives as one item on a valid/ready input stream and leaves as one item on a valid/ready output stream. A single register stage lies between them. An item is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. The result item is offered on the next cycle. It is held unchanged until the edge where `out_valid` and `out_ready` are both high. When the output is stalled, `in_ready` drops, so back-pressure passes straight to the producer. Decoding the instruction fields and delivering any exception both happen outside this block. The block only reports an inverted bit range through `out_illegal`.

Top module: `bitfield_unit`

## Requirements
- R1: Operation codes on `in_op` are: 0 word insert, 1 word extract, 2 doubleword insert, 3 doubleword extract, 4 word byte pick, 5 doubleword byte pick, 6 zero-if-rk-zero, 7 zero-if-rk-nonzero. An item accepted at one edge is offered on `out_valid` from the next cycle. While `out_valid` is high and `out_ready` is low, the output holds `out_result` and `out_illegal` stable and `in_ready` is low. Items leave in the order they were accepted.
- R2: Doubleword insert, with ls <= ms on 6-bit bounds, returns the old destination with bits ms..ls replaced by rj bits (ms-ls)..0. All other bits keep their old value.
- R3: Word insert uses only bits 4..0 of ms and ls and works on bits 31..0 of the old destination. The 32-bit result is sign-extended from bit 31.
- R4: Doubleword extract, with ls <= ms, returns rj bits ms..ls at bits (ms-ls)..0, with zeros above.
- R5: Word extract uses only bits 4..0 of ms and ls. It zero-fills rj bits ms..ls into the low bits and then sign-extends from bit 31.
- R6: For an insert or extract whose ls is greater than ms (compared on 5 bits for the word forms), `out_illegal` is 1 and `out_result` equals the old destination value unchanged.
- R7: Word byte pick, with sa taken from bits 1..0 of `in_sa`, forms {rk[31:0], rj[31:0]} and takes the 32 bits that start at bit 32-8*sa. The result is sign-extended. With sa = 0 the result is rk[31:0] sign-extended.
- R8: Doubleword byte pick forms {rk, rj} and takes the 64 bits that start at bit 64-8*sa, for sa from 0 to 7. With sa = 0 the result is rk.
- R9: Operation 6 returns 0 when rk is zero and rj otherwise. Operation 7 returns 0 when rk is nonzero and rj otherwise.
- R10: `out_illegal` is 0 for byte pick, for the mask operations, and for any insert or extract whose range is not inverted.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Unit can take an input item this cycle |
| in_op | input | 3 | Operation code |
| in_rj | input | 64 | First source |
| in_rk | input | 64 | Second source |
| in_rd_old | input | 64 | Old destination value |
| in_ms | input | 6 | Upper bit bound |
| in_ls | input | 6 | Lower bit bound |
| in_sa | input | 3 | Byte shift for byte pick |
| out_valid | output | 1 | Result item present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Result value |
| out_illegal | output | 1 | Inverted bit range on insert or extract |

## Verification
The bench sweeps every legal pair of bounds in both widths, including the ms = ls single-bit field and the full-width field. A mask generated off by one would corrupt a neighbouring bit or lose the top bit at these edges. Every inverted pair is also driven. A design that compared bounds on six bits for the word forms, or let such an item write the destination, would return a modified value or a clear flag there. Each byte-pick shift is tried, including sa = 0, where a design that wraps the shift amount would return rj instead of rk. Word results with bit 31 set expose a missing sign extension. Throughout, the consumer withdraws `out_ready` on a fixed pattern. A stage that dropped or repeated an item, or changed its output while stalled, would break the scoreboard order.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  typedef enum logic [2:0] {
    BF_INS_W      = 3'd0,
    BF_EXT_W      = 3'd1,
    BF_INS_D      = 3'd2,
    BF_EXT_D      = 3'd3,
    BF_PICK_W     = 3'd4,
    BF_PICK_D     = 3'd5,
    BF_ZERO_IF_Z  = 3'd6,
    BF_ZERO_IF_NZ = 3'd7
  } bf_op_e;

  // Operations that take a bit range; bit 0 then selects extract.
  function automatic logic is_field_op(input bf_op_e op);
    return (op == BF_INS_W) || (op == BF_EXT_W) ||
           (op == BF_INS_D) || (op == BF_EXT_D);
  endfunction

endpackage

// File: rtl/bf_field.sv
// Insert or extract over a field of width W, bounds given as bit indices.
module bf_field #(
  parameter int W = 64
) (
  input  logic [W-1:0]         src,
  input  logic [W-1:0]         old,
  input  logic [$clog2(W)-1:0] ms,
  input  logic [$clog2(W)-1:0] ls,
  input  logic                 extract,
  output logic [W-1:0]         result,
  output logic                 inverted
);
  localparam int PW = $clog2(W);
  localparam logic [PW-1:0] TOP = PW'(W - 1);

  logic [W-1:0] lo_mask;   // ones at ls and above
  logic [W-1:0] hi_mask;   // ones at ms and below
  logic [W-1:0] field;

  always_comb begin
    lo_mask  = {W{1'b1}} << ls;
    hi_mask  = {W{1'b1}} >> (TOP - ms);
    field    = lo_mask & hi_mask;
    inverted = (ls > ms);
    if (extract) result = (src & hi_mask) >> ls;
    else         result = (old & ~field) | ((src << ls) & field);
  end
endmodule

// File: rtl/bf_pick.sv
// Byte-aligned window across two concatenated sources, both widths.
module bf_pick #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]           rj,
  input  logic [DATA_W-1:0]           rk,
  input  logic [$clog2(DATA_W/8)-1:0] sa,
  output logic [DATA_W-1:0]           res_d,
  output logic [DATA_W-1:0]           res_w
);
  localparam int SA_W  = $clog2(DATA_W/8);
  localparam int HALF  = DATA_W / 2;
  localparam int SHD_W = $clog2(2 * DATA_W);
  localparam int SHW_W = $clog2(DATA_W);

  logic [2*DATA_W-1:0] cat_d, sh_d;
  logic [DATA_W-1:0]   cat_w, sh_w;
  logic [SHD_W-1:0]    amt_d;
  logic [SHW_W-1:0]    amt_w;
  logic [SA_W-2:0]     sa_w;

  always_comb begin
    sa_w  = sa[SA_W-2:0];
    amt_d = SHD_W'(DATA_W) - SHD_W'({sa, 3'b000});
    amt_w = SHW_W'(HALF)   - SHW_W'({sa_w, 3'b000});
    cat_d = {rk, rj};
    cat_w = {rk[HALF-1:0], rj[HALF-1:0]};
    sh_d  = cat_d >> amt_d;
    sh_w  = cat_w >> amt_w;
    res_d = sh_d[DATA_W-1:0];
    res_w = {{HALF{sh_w[HALF-1]}}, sh_w[HALF-1:0]};
  end
endmodule

// File: rtl/bf_mask.sv
// Pass rj or force zero depending on whether rk is zero.
module bf_mask #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] rj,
  input  logic [DATA_W-1:0] rk,
  input  logic              zero_on_nonzero,
  output logic [DATA_W-1:0] result
);
  logic rk_zero;
  always_comb begin
    rk_zero = (rk == '0);
    if (zero_on_nonzero ? !rk_zero : rk_zero) result = '0;
    else                                       result = rj;
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int DATA_W = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [2:0]                      in_op,
  input  logic [DATA_W-1:0]               in_rj,
  input  logic [DATA_W-1:0]               in_rk,
  input  logic [DATA_W-1:0]               in_rd_old,
  input  logic [$clog2(DATA_W)-1:0]       in_ms,
  input  logic [$clog2(DATA_W)-1:0]       in_ls,
  input  logic [$clog2(DATA_W/8)-1:0]     in_sa,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [DATA_W-1:0]               out_result,
  output logic                            out_illegal
);
  import bfu_pkg::*;

  localparam int POS_W = $clog2(DATA_W);
  localparam int NFORM = 2;   // index 0: doubleword, index 1: word

  bf_op_e              op;
  logic [DATA_W-1:0]   fld_res [NFORM];
  logic                fld_inv [NFORM];
  logic [DATA_W-1:0]   pick_d, pick_w, mask_res;
  logic [DATA_W-1:0]   nxt_result;
  logic                nxt_illegal;
  logic                accept;

  assign op = bf_op_e'(in_op);

  for (genvar g = 0; g < NFORM; g++) begin : g_form
    localparam int FW  = DATA_W >> g;
    localparam int FPW = $clog2(FW);
    logic [FW-1:0] r;
    logic          inv;
    bf_field #(.W(FW)) u_field (
      .src      (in_rj[FW-1:0]),
      .old      (in_rd_old[FW-1:0]),
      .ms       (in_ms[FPW-1:0]),
      .ls       (in_ls[FPW-1:0]),
      .extract  (in_op[0]),
      .result   (r),
      .inverted (inv)
    );
    if (FW == DATA_W) begin : g_full
      assign fld_res[g] = r;
    end else begin : g_sext
      assign fld_res[g] = {{(DATA_W-FW){r[FW-1]}}, r};
    end
    assign fld_inv[g] = inv;
  end

  bf_pick #(.DATA_W(DATA_W)) u_pick (
    .rj    (in_rj),
    .rk    (in_rk),
    .sa    (in_sa),
    .res_d (pick_d),
    .res_w (pick_w)
  );

  bf_mask #(.DATA_W(DATA_W)) u_mask (
    .rj              (in_rj),
    .rk              (in_rk),
    .zero_on_nonzero (in_op[0]),
    .result          (mask_res)
  );

  always_comb begin
    nxt_illegal = 1'b0;
    nxt_result  = mask_res;
    unique case (op)
      BF_INS_W, BF_EXT_W: begin
        nxt_illegal = fld_inv[1];
        nxt_result  = fld_res[1];
      end
      BF_INS_D, BF_EXT_D: begin
        nxt_illegal = fld_inv[0];
        nxt_result  = fld_res[0];
      end
      BF_PICK_W:                   nxt_result = pick_w;
      BF_PICK_D:                   nxt_result = pick_d;
      BF_ZERO_IF_Z, BF_ZERO_IF_NZ: nxt_result = mask_res;
      default:                     nxt_result = mask_res;
    endcase
    if (is_field_op(op) && nxt_illegal) nxt_result = in_rd_old;
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      if (accept) begin
        out_valid   <= 1'b1;
        out_result  <= nxt_result;
        out_illegal <= nxt_illegal;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [2:0]                  in_op,
  input logic [DATA_W-1:0]           in_rk,
  input logic [DATA_W-1:0]           in_rd_old,
  input logic [$clog2(DATA_W)-1:0]   in_ms,
  input logic [$clog2(DATA_W)-1:0]   in_ls,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [DATA_W-1:0]           out_result,
  input logic                        out_illegal
);
  localparam int HALF = DATA_W / 2;
  localparam int PW   = $clog2(DATA_W);

  logic acc, word_inv, dbl_inv;
  assign acc      = in_valid && in_ready;
  assign word_inv = (in_ls[PW-2:0] > in_ms[PW-2:0]);
  assign dbl_inv  = (in_ls > in_ms);

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal));

  a_r1_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r6_word_keep: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op[2:1] == 2'b00) && word_inv |=> out_illegal && (out_result == $past(in_rd_old)));

  a_r6_dbl_keep: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op[2:1] == 2'b01) && dbl_inv |=> out_illegal && (out_result == $past(in_rd_old)));

  a_r10_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op[2] |=> !out_illegal);

  a_r7_sext: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 3'd4) |=> out_result[DATA_W-1:HALF] == {HALF{out_result[HALF-1]}});

  a_r9_zero_if_z: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 3'd6) && (in_rk == '0) |=> out_result == '0);

  a_r9_zero_if_nz: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 3'd7) && (in_rk != '0) |=> out_result == '0);

endmodule

bind bitfield_unit bitfield_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .in_rk       (in_rk),
  .in_rd_old   (in_rd_old),
  .in_ms       (in_ms),
  .in_ls       (in_ls),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/test_bitfield_unit.sv
module test_bitfield_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [63:0] in_rj = '0, in_rk = '0, in_rd_old = '0;
  logic [5:0]  in_ms = '0, in_ls = '0;
  logic [2:0]  in_sa = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_result;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;

  typedef struct {
    logic [63:0] res;
    bit          ill;
    string       tag;
    string       itag;
  } exp_t;
  exp_t sb[$];

  bitfield_unit i_bitfield_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rj(in_rj), .in_rk(in_rk), .in_rd_old(in_rd_old),
    .in_ms(in_ms), .in_ls(in_ls), .in_sa(in_sa), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_illegal(out_illegal)
  );

  always #(PERIOD/2) clk = ~clk;

  // consumer stalls one cycle in four
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = (cyc % 4) != 2;
  end

  function automatic logic [63:0] sx32(input logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  function automatic logic [63:0] pat(input int k);
    logic [63:0] v;
    v = 64'h9E37_79B9_7F4A_7C15 * 64'(k + 1);
    return v ^ (v >> 29);
  endfunction

  // Reference model built from the requirements, bit by bit.
  task automatic model(input logic [2:0] op, input logic [63:0] rj, rk, rd,
                       input logic [5:0] ms, ls, input logic [2:0] sa,
                       output logic [63:0] res, output bit ill);
    logic [63:0] t;
    int m, l, s, idx;
    bit word;
    word = (op == 3'd0) || (op == 3'd1);
    m = word ? int'(ms[4:0]) : int'(ms);
    l = word ? int'(ls[4:0]) : int'(ls);
    ill = 0;
    res = '0;
    case (op)
      3'd0, 3'd2: begin
        if (l > m) begin ill = 1; res = rd; end
        else begin
          t = rd;
          for (int i = l; i <= m; i++) t[i] = rj[i-l];
          res = word ? sx32(t) : t;
        end
      end
      3'd1, 3'd3: begin
        if (l > m) begin ill = 1; res = rd; end
        else begin
          t = '0;
          for (int i = l; i <= m; i++) t[i-l] = rj[i];
          res = word ? sx32(t) : t;
        end
      end
      3'd4: begin
        s = int'(sa[1:0]);
        t = '0;
        for (int i = 0; i < 32; i++) begin
          idx = 32 - 8*s + i;
          t[i] = (idx < 32) ? rj[idx] : rk[idx-32];
        end
        res = sx32(t);
      end
      3'd5: begin
        s = int'(sa);
        for (int i = 0; i < 64; i++) begin
          idx = 64 - 8*s + i;
          res[i] = (idx < 64) ? rj[idx] : rk[idx-64];
        end
      end
      3'd6: res = (rk == 0) ? 64'd0 : rj;
      default: res = (rk != 0) ? 64'd0 : rj;
    endcase
  endtask

  task automatic send(input logic [2:0] op, input logic [63:0] rj, rk, rd,
                      input logic [5:0] ms, ls, input logic [2:0] sa, input string tag);
    exp_t e;
    bit acc;
    model(op, rj, rk, rd, ms, ls, sa, e.res, e.ill);
    e.tag  = tag;
    e.itag = (e.ill) ? "R6" : "R10";
    @(negedge clk);
    in_valid = 1; in_op = op; in_rj = rj; in_rk = rk; in_rd_old = rd;
    in_ms = ms; in_ls = ls; in_sa = sa;
    sb.push_back(e);
    acc = 0;
    while (!acc) begin
      #2 acc = in_ready;
      if (!acc) @(negedge clk);
    end
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  // Monitor: compares each result as it is handed over.
  logic [63:0] stall_res;
  bit          stalled = 0;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (stalled && out_valid) begin
        checks++;
        if (out_result !== stall_res) begin
          errors++;
          $display("FAIL R1 stalled result changed: got %h expected %h", out_result, stall_res);
        end
      end
      if (out_valid && !out_ready) begin
        checks++;
        if (in_ready) begin
          errors++;
          $display("FAIL R1 in_ready during stall: got 1 expected 0");
        end
      end
      stalled   = out_valid && !out_ready;
      stall_res = out_result;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R1 unexpected output: got %h expected none", out_result);
        end else begin
          exp_t e;
          e = sb.pop_front();
          checks += 2;
          if (out_result !== e.res) begin
            errors++;
            $display("FAIL %s result: got %h expected %h", e.tag, out_result, e.res);
          end
          if (out_illegal !== e.ill) begin
            errors++;
            $display("FAIL %s illegal flag: got %0d expected %0d", e.itag, out_illegal, e.ill);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int k = 0;
    repeat (3) @(negedge clk);
    #2;
    checks += 2;   // R11 reset state
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R11 out_valid: got %b expected 0", out_valid); end
    if (in_ready !== 1'b1) begin errors++; $display("FAIL R11 in_ready: got %b expected 1", in_ready); end
    @(negedge clk);
    rst_n = 1;

    // R2 / R4: every legal doubleword range, plus every inverted one (R6)
    for (int m = 0; m < 64; m++)
      for (int l = 0; l < 64; l++) begin
        k++;
        send(3'd2, pat(k), pat(k+7), pat(k+13), 6'(m), 6'(l), 3'd0, (l > m) ? "R6" : "R2");
        send(3'd3, pat(k+3), pat(k+5), pat(k+11), 6'(m), 6'(l), 3'd0, (l > m) ? "R6" : "R4");
      end

    // R3 / R5: every word range; bit 5 of the bounds must be ignored
    for (int m = 0; m < 32; m++)
      for (int l = 0; l < 32; l++) begin
        k++;
        send(3'd0, pat(k), pat(k+1), pat(k+2), {k[0], 5'(m)}, {k[1], 5'(l)}, 3'd0, (l > m) ? "R6" : "R3");
        send(3'd1, pat(k+4), pat(k+1), pat(k+9), {k[1], 5'(m)}, {k[0], 5'(l)}, 3'd0, (l > m) ? "R6" : "R5");
      end

    // R7 / R8: every shift, several data patterns including sa = 0
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 8; s++) begin
        send(3'd4, pat(100+p), pat(200+p) | 64'h8000_0000, 64'd0, 6'd0, 6'd0, 3'(s), "R7");
        send(3'd5, pat(300+p), pat(400+p), 64'd0, 6'd0, 6'd0, 3'(s), "R8");
      end
    send(3'd4, 64'h1111_2222_3333_4444, 64'h5555_6666_F777_8888, 64'd0, 6'd0, 6'd0, 3'd0, "R7");

    // R9: zero and nonzero conditions
    send(3'd6, pat(1), 64'd0, 64'd0, 6'd0, 6'd0, 3'd0, "R9");
    send(3'd6, pat(2), 64'd1, 64'd0, 6'd0, 6'd0, 3'd0, "R9");
    send(3'd6, pat(3), 64'h8000_0000_0000_0000, 64'd0, 6'd0, 6'd0, 3'd0, "R9");
    send(3'd7, pat(4), 64'd0, 64'd0, 6'd0, 6'd0, 3'd0, "R9");
    send(3'd7, pat(5), 64'd1, 64'd0, 6'd0, 6'd0, 3'd0, "R9");
    send(3'd7, pat(6), 64'h8000_0000_0000_0000, 64'd0, 6'd0, 6'd0, 3'd0, "R9");

    // drain
    for (int w = 0; w < 50 && sb.size() != 0; w++) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1 items left: got %0d expected 0", sb.size());
    end
    finish_run();
  end
endmodule